// File: doc/BRIEF.md
# Ready/Valid Queue with Pass-Through Options

This block is a first-in first-out buffer between a producer and a consumer. Each side uses a valid/ready handshake. Data words have a configurable width. The depth is configurable, any value of one or more, and need not be a power of two. Storage is a register array. An occupancy output always gives the exact number of words held.

Two compile-time options shorten the latency through the buffer:

- **Pipe option:** a full buffer still accepts a word in any cycle in which the consumer takes one.
- **Flow option:** an empty buffer hands an arriving word straight to its output in the same cycle.

A synchronous flush input empties the buffer. A parameter can tie the flush off.

Top module: `rvq_fifo`

## Requirements
- R1: Words leave in the order they were accepted, each unchanged. While the output is valid and not taken, its data holds steady.
- R2: A word moves on either side only in a cycle where both valid and ready on that side are high. A word offered while enq_ready_o is low is never delivered.
- R3: Without the pipe option, enq_ready_o is low exactly when count_o equals the depth.
- R4: Without the flow option, deq_valid_o is high exactly when count_o is non-zero.
- R5: count_o always equals the number of words accepted minus the number delivered, and never exceeds the depth.
- R6: With the pipe option, a full buffer whose consumer is ready raises enq_ready_o and takes a new word in that same cycle. enq_ready_o is low only when the buffer is full and deq_ready_i is low.
- R7: The pipe option works for a depth of one. With the consumer always ready, one word moves in and one moves out every cycle, and count_o stays at 1.
- R8: With the flow option and count_o at zero, deq_valid_o follows enq_valid_i and deq_data_o equals enq_data_i in the same cycle.
- R9: With the flow option, a word that passes straight through an empty buffer to a ready consumer leaves count_o at zero.
- R10: A cycle with flush_i high drops all held words and discards that cycle's enqueue. count_o is zero on the next cycle. With flush_i low the buffer works normally.
- R11: Read and write positions wrap modulo the depth, including depths that are not a power of two. Long streams through such a depth keep order.
- R12: After reset, count_o is 0, enq_ready_o is 1 and deq_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous clear of all contents |
| enq_valid_i | input | 1 | Producer offers a word |
| enq_ready_o | output | 1 | Buffer can take a word |
| enq_data_i | input | WIDTH | Offered word |
| deq_valid_o | output | 1 | A word is available |
| deq_ready_i | input | 1 | Consumer takes the word |
| deq_data_o | output | WIDTH | Head word |
| count_o | output | $clog2(DEPTH+1) | Words held |

## Verification
The most likely internal faults are these:

- A pointer that skips the wrap point.
- A read index that lags the write index.
- An occupancy register that misses an increment.

A pointer or index fault shows at the consumer port as a wrong or reordered word, usually on the first wrap after depth accepts. An occupancy fault breaks the agreement between count_o and the handshake signals within one cycle.

The scoreboard therefore compares every delivered word against its expected value. On every cycle it also checks count_o and the two handshake flags against a model occupancy. Some faults would leave the data intact, such as a bypass that also writes storage, or a flush that leaves a stale word. These surface as an occupancy mismatch or an unexpected valid on the next cycle.

// File: rtl/rvq_pkg.sv
package rvq_pkg;
  // pointer width that stays legal for a single-entry queue
  function automatic int unsigned ptr_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/rvq_ptr.sv
module rvq_ptr #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [PW-1:0] ptr_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (clr_i)   ptr_o <= '0;
    else if (adv_i)   ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  assert_ptr_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= LAST);
endmodule

// File: rtl/rvq_store.sv
module rvq_store #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PW    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [PW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [WIDTH-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ent_q <= '0;
      else if (we_i && waddr_i == PW'(g))       ent_q <= wdata_i;
    end
    assign ent[g] = ent_q;
  end

  assign rdata_o = ent[raddr_i];
endmodule

// File: rtl/rvq_occ.sv
module rvq_occ #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam logic [CW-1:0] TOP = CW'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_o <= '0;
    else if (clr_i)              cnt_o <= '0;
    else if (inc_i && !dec_i)    cnt_o <= cnt_o + 1'b1;
    else if (dec_i && !inc_i)    cnt_o <= cnt_o - 1'b1;
  end

  assign empty_o = (cnt_o == '0);
  assign full_o  = (cnt_o == TOP);

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= TOP);
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0 && !clr_i) |=> cnt_o <= CW'(1));
endmodule

// File: rtl/rvq_fifo.sv
module rvq_fifo #(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned DEPTH     = 4,
  parameter bit          PIPE      = 1'b0,
  parameter bit          FLOW      = 1'b0,
  parameter bit          HAS_FLUSH = 1'b1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       enq_valid_i,
  output logic                       enq_ready_o,
  input  logic [WIDTH-1:0]           enq_data_i,
  output logic                       deq_valid_o,
  input  logic                       deq_ready_i,
  output logic [WIDTH-1:0]           deq_data_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int unsigned PW = rvq_pkg::ptr_w(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          flush_eff, empty, full, bypass;
  logic          enq_fire, deq_fire, wr_en, rd_en;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [WIDTH-1:0] rd_data;

  if (HAS_FLUSH) begin : g_flush
    assign flush_eff = flush_i;
  end else begin : g_noflush
    assign flush_eff = 1'b0;
  end

  // flow: empty queue presents the incoming word directly
  assign bypass      = FLOW && empty;
  assign deq_valid_o = !empty || (FLOW && enq_valid_i);
  assign deq_data_o  = bypass ? enq_data_i : rd_data;
  // pipe: full queue may take a word when one leaves
  assign enq_ready_o = !full || (PIPE && deq_ready_i);

  assign enq_fire = enq_valid_i && enq_ready_o;
  assign deq_fire = deq_valid_o && deq_ready_i;
  assign wr_en    = enq_fire && !(bypass && deq_ready_i) && !flush_eff;
  assign rd_en    = deq_fire && !bypass;

  rvq_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wr_ptr (
    .clk_i, .rst_ni, .clr_i(flush_eff), .adv_i(wr_en), .ptr_o(wr_ptr)
  );

  rvq_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rd_ptr (
    .clk_i, .rst_ni, .clr_i(flush_eff), .adv_i(rd_en), .ptr_o(rd_ptr)
  );

  rvq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) u_store (
    .clk_i, .rst_ni, .we_i(wr_en), .waddr_i(wr_ptr), .wdata_i(enq_data_i),
    .raddr_i(rd_ptr), .rdata_o(rd_data)
  );

  rvq_occ #(.DEPTH(DEPTH), .CW(CW)) u_occ (
    .clk_i, .rst_ni, .clr_i(flush_eff), .inc_i(wr_en), .dec_i(rd_en),
    .cnt_o(count_o), .empty_o(empty), .full_o(full)
  );

  assert_flush_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_eff |=> (count_o == '0));

  assert_head_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_valid_o && !deq_ready_i && !empty && !flush_eff)
      |=> (deq_valid_o && $stable(deq_data_o)));

  assert_valid_when_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != '0) |-> deq_valid_o);

  if (PIPE) begin : g_pipe_chk
    assert_pipe_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (count_o == CW'(DEPTH) && deq_ready_i) |-> enq_ready_o);
  end

  if (FLOW) begin : g_flow_chk
    assert_bypass_no_store_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (count_o == '0 && enq_valid_i && deq_ready_i && !flush_eff) |=> (count_o == '0));
  end
endmodule

// File: tb/rvq_fifo_bench.sv
module rvq_sb #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 3,
  parameter int unsigned CW    = 2,
  parameter bit          PIPE  = 1'b0,
  parameter bit          FLOW  = 1'b0,
  parameter string       NAME  = "q"
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fl,
  input  logic          ev,
  input  logic          er,
  input  logic [W-1:0]  ed,
  input  logic          dv,
  input  logic          dr,
  input  logic [W-1:0]  dd,
  input  logic [CW-1:0] cnt,
  output int            checks_o,
  output int            errs_o
);
  logic [W-1:0] exp_q[$];
  logic [W-1:0] e;
  int n_chk = 0;
  int n_err = 0;
  int model = 0;

  assign checks_o = n_chk;
  assign errs_o   = n_err;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      n_chk++;
      if (int'(cnt) != model) begin
        n_err++; $display("FAIL R5 %s count act=%0d exp=%0d", NAME, cnt, model);
      end
      if (!PIPE) begin
        n_chk++;
        if (er != (int'(cnt) != DEPTH)) begin
          n_err++; $display("FAIL R3 %s enq_ready act=%0b exp=%0b", NAME, er, int'(cnt) != DEPTH);
        end
      end else if (int'(cnt) == DEPTH && dr) begin
        n_chk++;
        if (!er) begin
          n_err++; $display("FAIL R6 %s enq_ready act=0 exp=1", NAME);
        end
      end
      if (!FLOW) begin
        n_chk++;
        if (dv != (cnt != 0)) begin
          n_err++; $display("FAIL R4 %s deq_valid act=%0b exp=%0b", NAME, dv, cnt != 0);
        end
      end else if (cnt == 0) begin
        n_chk++;
        if (dv != ev || (ev && dd != ed)) begin
          n_err++; $display("FAIL R8 %s bypass act=%0b/%0h exp=%0b/%0h", NAME, dv, dd, ev, ed);
        end
      end
      if (ev && er && !fl) exp_q.push_back(ed);
      if (dv && dr) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_err++; $display("FAIL R2 %s delivery from empty act=%0h exp=none", NAME, dd);
        end else begin
          e = exp_q.pop_front();
          if (dd != e) begin
            n_err++; $display("FAIL R1 %s data act=%0h exp=%0h", NAME, dd, e);
          end
        end
      end
      if (fl) exp_q.delete();
      model = exp_q.size();
    end
  end
endmodule

module rvq_fifo_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // default instance: depth 3, no pipe, no flow
  logic       a_fl = 0, a_ev = 0, a_er, a_dv, a_dr = 0;
  logic [7:0] a_ed = 0, a_dd;
  logic [1:0] a_cnt;
  // pipe instance: depth 1
  logic       p_fl = 0, p_ev = 0, p_er, p_dv, p_dr = 0;
  logic [7:0] p_ed = 0, p_dd;
  logic [0:0] p_cnt;
  // flow instance: depth 3
  logic       f_fl = 0, f_ev = 0, f_er, f_dv, f_dr = 0;
  logic [7:0] f_ed = 0, f_dd;
  logic [1:0] f_cnt;

  rvq_fifo #(.WIDTH(8), .DEPTH(3)) u_rvq_fifo (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(a_fl), .enq_valid_i(a_ev), .enq_ready_o(a_er),
    .enq_data_i(a_ed), .deq_valid_o(a_dv), .deq_ready_i(a_dr), .deq_data_o(a_dd), .count_o(a_cnt)
  );
  rvq_fifo #(.WIDTH(8), .DEPTH(1), .PIPE(1'b1)) u_rvq_fifo_pipe (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(p_fl), .enq_valid_i(p_ev), .enq_ready_o(p_er),
    .enq_data_i(p_ed), .deq_valid_o(p_dv), .deq_ready_i(p_dr), .deq_data_o(p_dd), .count_o(p_cnt)
  );
  rvq_fifo #(.WIDTH(8), .DEPTH(3), .FLOW(1'b1)) u_rvq_fifo_flow (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(f_fl), .enq_valid_i(f_ev), .enq_ready_o(f_er),
    .enq_data_i(f_ed), .deq_valid_o(f_dv), .deq_ready_i(f_dr), .deq_data_o(f_dd), .count_o(f_cnt)
  );

  int a_c, a_e, p_c, p_e, f_c, f_e;
  rvq_sb #(.DEPTH(3), .CW(2), .NAME("base")) u_sb_a (
    .clk_i(clk), .rst_ni(rst_n), .fl(a_fl), .ev(a_ev), .er(a_er), .ed(a_ed), .dv(a_dv),
    .dr(a_dr), .dd(a_dd), .cnt(a_cnt), .checks_o(a_c), .errs_o(a_e)
  );
  rvq_sb #(.DEPTH(1), .CW(1), .PIPE(1'b1), .NAME("pipe")) u_sb_p (
    .clk_i(clk), .rst_ni(rst_n), .fl(p_fl), .ev(p_ev), .er(p_er), .ed(p_ed), .dv(p_dv),
    .dr(p_dr), .dd(p_dd), .cnt(p_cnt), .checks_o(p_c), .errs_o(p_e)
  );
  rvq_sb #(.DEPTH(3), .CW(2), .FLOW(1'b1), .NAME("flow")) u_sb_f (
    .clk_i(clk), .rst_ni(rst_n), .fl(f_fl), .ev(f_ev), .er(f_er), .ed(f_ed), .dv(f_dv),
    .dr(f_dr), .dd(f_dd), .cnt(f_cnt), .checks_o(f_c), .errs_o(f_e)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors",
             checks + a_c + p_c + f_c, errors + a_e + p_e + f_e);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    bit fired;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(a_cnt == 0, "R12 count", a_cnt, 0);
    chk(a_er == 1, "R12 enq_ready", a_er, 1);
    chk(a_dv == 0, "R12 deq_valid", a_dv, 0);
    chk(f_dv == 0, "R8 flow idle valid", f_dv, 0);

    // R3 fill past depth; words offered while full are ignored (R2)
    @(posedge clk); #1 a_ev = 1;
    for (int i = 0; i < 5; i++) begin
      a_ed = 8'(8'h10 + i);
      @(posedge clk); #1;
    end
    a_ev = 0;
    @(negedge clk);
    chk(a_cnt == 3, "R3 full count", a_cnt, 3);
    chk(a_er == 0, "R3 ready low when full", a_er, 0);
    chk(a_dv == 1 && a_dd == 8'h10, "R1 head word", a_dd, 8'h10);
    @(posedge clk); #1 a_dr = 1;
    repeat (3) @(posedge clk);
    #1 a_dr = 0;
    @(negedge clk);
    chk(a_cnt == 0, "R4 drained count", a_cnt, 0);
    chk(a_dv == 0, "R4 valid low when empty", a_dv, 0);

    // R11 long random stream through depth 3
    fired = 0; a_ed = 8'h20;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      if (fired) a_ed = 8'(a_ed + 1);
      a_ev = ($urandom % 4) != 0;
      a_dr = ($urandom % 3) != 0;
      @(negedge clk);
      fired = a_ev && a_er;
    end
    @(posedge clk); #1 a_ev = 0; a_dr = 1;
    repeat (4) @(posedge clk);
    #1 a_dr = 0;
    @(negedge clk);
    chk(a_cnt == 0, "R11 empty after wrap stream", a_cnt, 0);

    // R10 flush with a simultaneous enqueue
    @(posedge clk); #1 a_ev = 1; a_ed = 8'h41;
    @(posedge clk); #1 a_ed = 8'h42;
    @(posedge clk); #1 a_ed = 8'h77; a_fl = 1;
    @(posedge clk); #1 a_fl = 0; a_ev = 0;
    @(negedge clk);
    chk(a_cnt == 0, "R10 count after flush", a_cnt, 0);
    chk(a_dv == 0, "R10 valid after flush", a_dv, 0);
    @(posedge clk); #1 a_ev = 1; a_ed = 8'h55;
    @(posedge clk); #1 a_ev = 0; a_dr = 1;
    @(negedge clk);
    chk(a_dv == 1 && a_dd == 8'h55, "R10 first word after flush", a_dd, 8'h55);
    @(posedge clk); #1 a_dr = 0;

    // R6/R7 pipe, depth 1
    p_ev = 1; p_ed = 8'hA0;
    @(posedge clk); #1 p_ed = 8'hA1;
    @(negedge clk);
    chk(p_er == 0, "R6 full and consumer idle", p_er, 0);
    chk(p_cnt == 1, "R7 single entry held", p_cnt, 1);
    @(posedge clk); #1 p_dr = 1;
    @(negedge clk);
    chk(p_er == 1, "R6 same-cycle accept when full", p_er, 1);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1 p_ed = 8'(p_ed + 1);
      @(negedge clk);
      chk(p_cnt == 1 && p_er == 1, "R7 one in one out", p_cnt, 1);
    end
    fired = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      if (fired) p_ed = 8'(p_ed + 1);
      p_ev = ($urandom % 3) != 0;
      p_dr = ($urandom % 3) != 0;
      @(negedge clk);
      fired = p_ev && p_er;
    end
    @(posedge clk); #1 p_ev = 0; p_dr = 1;
    repeat (2) @(posedge clk);
    #1 p_dr = 0;

    // R8/R9 flow, depth 3
    @(negedge clk);
    chk(f_dv == 0, "R8 empty without input", f_dv, 0);
    @(posedge clk); #1 f_ev = 1; f_ed = 8'h5A; f_dr = 1;
    @(negedge clk);
    chk(f_dv == 1 && f_dd == 8'h5A, "R8 same-cycle pass", f_dd, 8'h5A);
    @(posedge clk); #1 f_ev = 0; f_dr = 0;
    @(negedge clk);
    chk(f_cnt == 0, "R9 bypass leaves count zero", f_cnt, 0);
    @(posedge clk); #1 f_ev = 1; f_ed = 8'h61;
    @(posedge clk); #1 f_ed = 8'h62;
    @(posedge clk); #1 f_ev = 0;
    @(negedge clk);
    chk(f_cnt == 2, "R5 flow stores when consumer idle", f_cnt, 2);
    fired = 0; f_ed = 8'h70;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      if (fired) f_ed = 8'(f_ed + 1);
      f_ev = ($urandom % 2) != 0;
      f_dr = ($urandom % 3) != 0;
      @(negedge clk);
      fired = f_ev && f_er;
    end
    @(posedge clk); #1 f_ev = 0; f_dr = 1;
    repeat (4) @(posedge clk);
    #1 f_dr = 0;
    @(negedge clk);
    chk(f_cnt == 0 && f_dv == 0, "R8 idle after drain", f_cnt, 0);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule